// File: doc/BRIEF.md
# Hardware Performance Monitor Counters

This block keeps the performance counters of a processor core behind a control-register access port. It holds a free-running cycle counter, a counter of retired instructions and six general event counters. Each general counter has its own selector register that picks one source from a fixed set of 22 single-cycle event pulses. The pulses come from the caches, TLBs and pipeline. A stop register can freeze any counter. Two enable registers decide whether supervisor and user software may read the counters through read-only shadow addresses.

Software reaches the block through a combinational access port. An access is qualified by `csr_en_i`. A write takes effect at the next rising clock edge. The read data and the illegal-access flag answer in the same cycle as the address. In the default 32-bit configuration every 64-bit counter has a low-half address and a high-half address. A denied access raises `csr_illegal_o`, returns zero and changes nothing. The surrounding pipeline turns that flag into a trap.

Counter index k is 0 for the cycle counter, 2 for the retired-instruction counter and 3 to 8 for the general counters. Index 1 is not provided. The address map is:

- machine counter, low half: `0xB00 + k`
- machine counter, high half: `0xB80 + k`
- read-only shadow counter, low half: `0xC00 + k`
- read-only shadow counter, high half: `0xC80 + k`
- stop register: `0x320`
- selector of counter k (k = 3 to 8): `0x320 + k`
- supervisor-read enable register (machine level): `0x306`
- user-read enable register (supervisor level): `0x106`

Bits 9:8 of an address give the lowest privilege that may use it. The privilege input is coded 0 for user, 1 for supervisor and 3 for machine.

Top module: `hpm_monitor`

## Requirements
- R1: After reset every counter, every selector, the stop register and both enable registers read as zero.
- R2: The cycle counter adds one on every clock edge. The retired-instruction counter adds one on every edge where `retire_i` is high. Each only counts while its stop bit is clear.
- R3: General counter k adds one on an edge where input bit `event_i[s-1]` is high, s being its selector value. A selector of 0 or any value above 22 counts nothing. The bits of `event_i`, from 0 upward, are: instruction-cache miss, data-cache miss, instruction-TLB miss, data-TLB miss, load, store, exception, return from exception handler, branch, mispredicted branch, branch exception, call, return, store buffer full, empty fetch queue, instruction-cache access, data-cache access, cache line invalidation, instruction-TLB flush, integer instruction, floating-point instruction, pipeline bubble.
- R4: Bit k of the stop register (`0x320`) freezes counter k. A write to a frozen counter still loads the written value.
- R5: When a write and an increment reach the same counter on the same edge, the counter holds exactly the written value afterwards.
- R6: A write to a low-half address replaces bits 31:0 only. A write to a high-half address replaces bits 63:32 only. A high-half address reads bits 63:32.
- R7: A shadow address (`0xC00 + k`, `0xC80 + k`) returns the same value as the matching machine address.
- R8: Machine mode may always read a shadow address. Supervisor mode needs bit k of the supervisor-read enable register. User mode needs bit k in both enable registers. An address whose bits 9:8 exceed the current privilege is refused.
- R9: Any refused access raises `csr_illegal_o`, reads as zero and changes no state. Refused accesses are: a denied read, any write to a shadow address, an unmapped address (counter index 1, index above 8, and any other unused code), and a privilege below the address level.
- R10: In the stop register and both enable registers only bits 0 and 2 to 8 are writable. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_en_i | input | 1 | Access valid in this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| retire_i | input | 1 | One instruction retired this cycle |
| event_i | input | NUM_EVENTS | Event pulses, one bit per source |
| csr_rdata_o | output | XLEN | Read data, zero when no access or refused |
| csr_illegal_o | output | 1 | Access refused |

## Verification
The hardest case to reach from the ports is a write that lands on a counter in the very edge where that counter also counts. The stimulus holds every event line high and points a selector at a frequent source, so the counter steps on every edge. It then writes the counter and reads it back on the next cycle, where any leaked increment shows up as an off-by-one. The two-level read gating is walked in directed order: each enable bit is set one at a time while shadow reads are tried from user, supervisor and machine mode. A constrained-random phase then mixes random privileges, addresses and register writes.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    localparam int CNT_W = 64;
    localparam int IDX_W = 5;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [3:0]  MCNT_PAGE    = 4'hB;
    localparam logic [3:0]  UCNT_PAGE    = 4'hC;
    localparam logic [11:0] ADDR_STOP    = 12'h320;
    localparam logic [11:0] ADDR_SUP_EN  = 12'h306;
    localparam logic [11:0] ADDR_USR_EN  = 12'h106;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_COUNTER,
        ACC_SELECT,
        ACC_STOP,
        ACC_SUP_EN,
        ACC_USR_EN
    } acc_kind_e;

endpackage

// File: rtl/hpm_event_sel.sv
module hpm_event_sel #(
    parameter int NUM_EVENTS = 22,
    parameter int SEL_W      = 5
) (
    input  logic [NUM_EVENTS-1:0] event_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic                  hit_o
);

    logic [NUM_EVENTS-1:0] match;

    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_src
        assign match[e] = event_i[e] && (sel_i == SEL_W'(e + 1));
    end

    assign hit_o = |match;

endmodule

// File: rtl/hpm_counter.sv
module hpm_counter #(
    parameter int XLEN = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      inc_i,
    input  logic                      stop_i,
    input  logic                      wr_lo_i,
    input  logic                      wr_hi_i,
    input  logic [XLEN-1:0]           wdata_i,
    output logic [hpm_pkg::CNT_W-1:0] cnt_o
);
    import hpm_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wr_val;
    logic             wr_any;

    assign wr_any = wr_lo_i || wr_hi_i;

    if (XLEN == 32) begin : g_split
        always_comb begin
            if (wr_hi_i) wr_val = {wdata_i, cnt_q[31:0]};
            else         wr_val = {cnt_q[CNT_W-1:32], wdata_i};
        end

        // R6: a low-half write leaves the upper half alone
        p_other_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_lo_i && !wr_hi_i) |=> cnt_q[CNT_W-1:32] == $past(cnt_q[CNT_W-1:32]));
    end else begin : g_full
        assign wr_val = CNT_W'(wdata_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (wr_any)            cnt_q <= wr_val;
        else if (inc_i && !stop_i)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    p_write_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_lo_i |=> cnt_q[XLEN-1:0] == $past(wdata_i));

    p_stop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !wr_any) |=> $stable(cnt_q));

    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !stop_i && !wr_any) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/hpm_access.sv
module hpm_access #(
    parameter int XLEN    = 32,
    parameter int NUM_CNT = 9
) (
    input  logic [11:0]               addr_i,
    input  logic [1:0]                priv_i,
    input  logic                      en_i,
    input  logic                      we_i,
    input  logic [NUM_CNT-1:0]        sup_en_i,
    input  logic [NUM_CNT-1:0]        usr_en_i,
    output hpm_pkg::acc_kind_e        kind_o,
    output logic [hpm_pkg::IDX_W-1:0] idx_o,
    output logic                      hi_o,
    output logic                      illegal_o
);
    import hpm_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_CNT - 1);
    localparam logic [IDX_W-1:0] FIRST_GEN = IDX_W'(3);
    localparam logic             HAS_HI    = (XLEN == 32);

    logic [31:0] sup_ext, usr_ext;
    logic        shadow, gate_ok, level_ok;

    assign idx_o   = addr_i[IDX_W-1:0];
    assign hi_o    = addr_i[7];
    assign shadow  = (addr_i[11:8] == UCNT_PAGE);
    assign sup_ext = 32'(sup_en_i);
    assign usr_ext = 32'(usr_en_i);

    always_comb begin
        kind_o = ACC_NONE;
        if ((addr_i[11:8] == MCNT_PAGE || shadow) && addr_i[6:5] == 2'b00 &&
            idx_o <= LAST_IDX && idx_o != IDX_W'(1) && (!addr_i[7] || HAS_HI))
            kind_o = ACC_COUNTER;
        else if (addr_i == ADDR_STOP)
            kind_o = ACC_STOP;
        else if (addr_i[11:5] == ADDR_STOP[11:5] && idx_o >= FIRST_GEN && idx_o <= LAST_IDX)
            kind_o = ACC_SELECT;
        else if (addr_i == ADDR_SUP_EN)
            kind_o = ACC_SUP_EN;
        else if (addr_i == ADDR_USR_EN)
            kind_o = ACC_USR_EN;
    end

    always_comb begin
        case (priv_i)
            PRIV_M:  gate_ok = 1'b1;
            PRIV_U:  gate_ok = sup_ext[idx_o] && usr_ext[idx_o];
            default: gate_ok = sup_ext[idx_o];
        endcase
    end

    assign level_ok  = (priv_i >= addr_i[9:8]);
    assign illegal_o = en_i && (kind_o == ACC_NONE || !level_ok ||
                                (shadow && (we_i || !gate_ok)));

endmodule

// File: rtl/hpm_monitor.sv
module hpm_monitor #(
    parameter int XLEN       = 32,
    parameter int NUM_GEN    = 6,
    parameter int NUM_EVENTS = 22
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  csr_en_i,
    input  logic                  csr_we_i,
    input  logic [11:0]           csr_addr_i,
    input  logic [XLEN-1:0]       csr_wdata_i,
    input  logic [1:0]            priv_i,
    input  logic                  retire_i,
    input  logic [NUM_EVENTS-1:0] event_i,
    output logic [XLEN-1:0]       csr_rdata_o,
    output logic                  csr_illegal_o
);
    import hpm_pkg::*;

    localparam int NUM_CNT = NUM_GEN + 3;
    localparam int SEL_W   = $clog2(NUM_EVENTS + 1);
    localparam logic [NUM_CNT-1:0] BIT_MASK = ~(NUM_CNT'(2));

    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic               hi;
    logic               wr_ok;
    logic [NUM_CNT-1:0] stop_q, sup_en_q, usr_en_q;
    logic [SEL_W-1:0]   sel_q [3:NUM_CNT-1];
    logic [CNT_W-1:0]   cnt_w [NUM_CNT];
    logic [XLEN-1:0]    rd_val;

    hpm_access #(.XLEN(XLEN), .NUM_CNT(NUM_CNT)) u_access (
        .addr_i    (csr_addr_i),
        .priv_i    (priv_i),
        .en_i      (csr_en_i),
        .we_i      (csr_we_i),
        .sup_en_i  (sup_en_q),
        .usr_en_i  (usr_en_q),
        .kind_o    (kind),
        .idx_o     (idx),
        .hi_o      (hi),
        .illegal_o (csr_illegal_o)
    );

    assign wr_ok = csr_en_i && csr_we_i && !csr_illegal_o;

    // control registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stop_q   <= '0;
            sup_en_q <= '0;
            usr_en_q <= '0;
        end else if (wr_ok) begin
            unique case (kind)
                ACC_STOP:   stop_q   <= csr_wdata_i[NUM_CNT-1:0] & BIT_MASK;
                ACC_SUP_EN: sup_en_q <= csr_wdata_i[NUM_CNT-1:0] & BIT_MASK;
                ACC_USR_EN: usr_en_q <= csr_wdata_i[NUM_CNT-1:0] & BIT_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 3; i < NUM_CNT; i++) sel_q[i] <= '0;
        end else if (wr_ok && kind == ACC_SELECT) begin
            for (int i = 3; i < NUM_CNT; i++)
                if (idx == IDX_W'(i)) sel_q[i] <= csr_wdata_i[SEL_W-1:0];
        end
    end

    // counters
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        if (i == 1) begin : g_absent
            assign cnt_w[i] = '0;
        end else begin : g_live
            logic inc, wr_lo, wr_hi;

            if (i == 0) begin : g_cycle
                assign inc = 1'b1;
            end else if (i == 2) begin : g_retire
                assign inc = retire_i;
            end else begin : g_event
                hpm_event_sel #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_sel (
                    .event_i (event_i),
                    .sel_i   (sel_q[i]),
                    .hit_o   (inc)
                );

                // R3: an idle selector never moves the counter
                p_sel_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (sel_q[i] == '0 && !wr_lo && !wr_hi) |=> $stable(cnt_w[i]));
            end

            assign wr_lo = wr_ok && kind == ACC_COUNTER && idx == IDX_W'(i) && !hi;
            assign wr_hi = wr_ok && kind == ACC_COUNTER && idx == IDX_W'(i) && hi;

            hpm_counter #(.XLEN(XLEN)) u_counter (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .inc_i   (inc),
                .stop_i  (stop_q[i]),
                .wr_lo_i (wr_lo),
                .wr_hi_i (wr_hi),
                .wdata_i (csr_wdata_i),
                .cnt_o   (cnt_w[i])
            );

            // R8: user shadow read needs both enable bits
            p_user_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (csr_en_i && priv_i == PRIV_U && csr_addr_i == 12'hC00 + 12'(i) &&
                 !(sup_en_q[i] && usr_en_q[i])) |-> csr_illegal_o);
        end
    end

    // read path
    always_comb begin
        rd_val = '0;
        unique case (kind)
            ACC_COUNTER: begin
                for (int i = 0; i < NUM_CNT; i++)
                    if (idx == IDX_W'(i))
                        rd_val = hi ? XLEN'(cnt_w[i][CNT_W-1:32]) : cnt_w[i][XLEN-1:0];
            end
            ACC_SELECT: begin
                for (int i = 3; i < NUM_CNT; i++)
                    if (idx == IDX_W'(i)) rd_val = XLEN'(sel_q[i]);
            end
            ACC_STOP:   rd_val = XLEN'(stop_q);
            ACC_SUP_EN: rd_val = XLEN'(sup_en_q);
            ACC_USR_EN: rd_val = XLEN'(usr_en_q);
            default:    rd_val = '0;
        endcase
    end

    assign csr_rdata_o = (csr_en_i && !csr_illegal_o) ? rd_val : '0;

    p_refused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_illegal_o |-> csr_rdata_o == '0);

    p_shadow_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_en_i && csr_we_i && csr_addr_i[11:8] == UCNT_PAGE) |-> csr_illegal_o);

endmodule

// File: tb/tb_hpm_monitor.sv
module tb_hpm_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  priv = 2'd3;
    logic        retire = 1'b0;
    logic [21:0] ev = '0;
    logic [31:0] rdata;
    logic        illegal;
    logic        rand_ev = 1'b0;
    logic        done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] m_cnt [9];
    logic [8:0]  m_stop, m_sup, m_usr;
    logic [4:0]  m_sel [9];

    always #10 clk = ~clk;

    hpm_monitor dut (
        .clk_i(clk), .rst_ni(rst_n), .csr_en_i(en), .csr_we_i(we),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .priv_i(priv),
        .retire_i(retire), .event_i(ev),
        .csr_rdata_o(rdata), .csr_illegal_o(illegal)
    );

    // kind: 0 none, 1 counter, 2 selector, 3 stop, 4 sup enable, 5 usr enable
    function automatic int f_kind(input logic [11:0] a);
        int k = int'(a[4:0]);
        if ((a[11:8] == 4'hB || a[11:8] == 4'hC) && a[6:5] == 2'b00 && k <= 8 && k != 1) return 1;
        if (a == 12'h320) return 3;
        if (a[11:5] == 7'h19 && k >= 3 && k <= 8) return 2;
        if (a == 12'h306) return 4;
        if (a == 12'h106) return 5;
        return 0;
    endfunction

    function automatic bit f_illegal(input logic [11:0] a, input logic [1:0] p, input logic w);
        int k = int'(a[4:0]);
        if (f_kind(a) == 0) return 1'b1;
        if (p < a[9:8]) return 1'b1;
        if (a[11:8] == 4'hC) begin
            if (w) return 1'b1;
            if (p == 2'd3) return 1'b0;
            if (p == 2'd0) return !(m_sup[k] && m_usr[k]);
            return !m_sup[k];
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] f_read(input logic [11:0] a);
        int k = int'(a[4:0]);
        case (f_kind(a))
            1: return a[7] ? m_cnt[k][63:32] : m_cnt[k][31:0];
            2: return 32'(m_sel[k]);
            3: return 32'(m_stop);
            4: return 32'(m_sup);
            5: return 32'(m_usr);
            default: return 32'h0;
        endcase
    endfunction

    // reference model, updated on the same edges as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) begin m_cnt[i] <= '0; m_sel[i] <= '0; end
            m_stop <= '0; m_sup <= '0; m_usr <= '0;
        end else begin
            bit wr_ok;
            int k;
            wr_ok = en && we && !f_illegal(addr, priv, we);
            k = int'(addr[4:0]);
            for (int i = 0; i < 9; i++) begin
                bit inc;
                int s;
                s = int'(m_sel[i]);
                if (i == 0) inc = 1'b1;
                else if (i == 2) inc = retire;
                else if (i >= 3) inc = (s >= 1 && s <= 22) ? ev[s-1] : 1'b0;
                else inc = 1'b0;
                if (i != 1) begin
                    if (wr_ok && f_kind(addr) == 1 && k == i) begin
                        if (addr[7]) m_cnt[i] <= {wdata, m_cnt[i][31:0]};
                        else         m_cnt[i] <= {m_cnt[i][63:32], wdata};
                    end else if (inc && !m_stop[i]) begin
                        m_cnt[i] <= m_cnt[i] + 64'd1;
                    end
                end
            end
            if (wr_ok) begin
                case (f_kind(addr))
                    2: m_sel[k] <= wdata[4:0];
                    3: m_stop <= wdata[8:0] & 9'h1FD;
                    4: m_sup  <= wdata[8:0] & 9'h1FD;
                    5: m_usr  <= wdata[8:0] & 9'h1FD;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rand_ev) begin
            ev = 22'($urandom);
            retire = 1'($urandom);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] p, input string req);
        bit          e_ill;
        logic [31:0] e_dat;
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = a; priv = p;
        #2;
        e_ill = f_illegal(a, p, 1'b0);
        e_dat = e_ill ? 32'h0 : f_read(a);
        chk(illegal == e_ill, req, 64'(illegal), 64'(e_ill));
        chk(rdata == e_dat, req, 64'(rdata), 64'(e_dat));
        @(negedge clk);
        en = 1'b0;
    endtask

    // write, then read the same address back on the next cycle
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] p, input string req);
        bit          e_ill;
        logic [31:0] e_dat;
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = a; wdata = d; priv = p;
        #2;
        e_ill = f_illegal(a, p, 1'b1);
        chk(illegal == e_ill, req, 64'(illegal), 64'(e_ill));
        @(negedge clk);
        we = 1'b0;
        #2;
        e_ill = f_illegal(a, p, 1'b0);
        e_dat = e_ill ? 32'h0 : f_read(a);
        chk(rdata == e_dat, req, 64'(rdata), 64'(e_dat));
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic rd_val(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = a; priv = 2'd3;
        #2 v = rdata;
        @(negedge clk);
        en = 1'b0;
    endtask

    function automatic logic [11:0] pick_addr();
        int r = int'($urandom % 8);
        logic [3:0] pg;
        logic [4:0] k;
        if (r < 4) begin
            pg = ($urandom % 2) ? 4'hB : 4'hC;
            k  = 5'($urandom % 10);
            return {pg, 1'($urandom), 2'b00, k};
        end
        if (r == 4) return 12'h320 + 12'($urandom % 10);
        if (r == 5) return 12'h306;
        if (r == 6) return 12'h106;
        return 12'($urandom);
    endfunction

    function automatic string tag_of(input logic [11:0] a, input logic [1:0] p);
        if (f_illegal(a, p, 1'b0)) return "R9";
        if (a[11:8] == 4'hC) return "R7";
        if (f_kind(a) == 1) return "R3";
        return "R10";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v1, v2;
        void'($urandom(32'd20240611));

        // R1: reset values, read while reset is held
        repeat (3) @(negedge clk);
        foreach (m_cnt[i]) begin
            if (i != 1) begin
                rd(12'hB00 + 12'(i), 2'd3, "R1");
                rd(12'hB80 + 12'(i), 2'd3, "R1");
            end
        end
        for (int i = 3; i < 9; i++) rd(12'h320 + 12'(i), 2'd3, "R1");
        rd(12'h320, 2'd3, "R1");
        rd(12'h306, 2'd3, "R1");
        rd(12'h106, 2'd3, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: cycle and retired counters
        repeat (5) @(negedge clk);
        rd(12'hB00, 2'd3, "R2");
        retire = 1'b1;
        repeat (4) @(negedge clk);
        retire = 1'b0;
        rd(12'hB02, 2'd3, "R2");
        rd_val(12'hB00, v1);
        rd_val(12'hB00, v2);
        chk(v2 - v1 == 32'd2, "R2", 64'(v2 - v1), 64'd2);

        // R3: selector mapping, idle and out-of-range selectors
        wr(12'h323, 32'd5,  2'd3, "R3");
        wr(12'h324, 32'd0,  2'd3, "R3");
        wr(12'h325, 32'd23, 2'd3, "R3");
        wr(12'h326, 32'd22, 2'd3, "R3");
        wr(12'h327, 32'd1,  2'd3, "R3");
        @(negedge clk);
        ev = 22'h3FFFFE;
        repeat (10) @(negedge clk);
        ev = '0;
        for (int i = 3; i < 9; i++) rd(12'hB00 + 12'(i), 2'd3, "R3");
        rd_val(12'hB04, v1);
        chk(v1 == 32'd0, "R3", 64'(v1), 64'd0);
        rd_val(12'hB05, v1);
        chk(v1 == 32'd0, "R3", 64'(v1), 64'd0);
        rd_val(12'hB07, v1);
        chk(v1 == 32'd0, "R3", 64'(v1), 64'd0);
        rd_val(12'hB03, v1);
        chk(v1 == 32'd10, "R3", 64'(v1), 64'd10);

        // R4: stop bits freeze, writes still land
        wr(12'h320, 32'h9, 2'd3, "R4");
        rd_val(12'hB00, v1);
        ev = 22'h3FFFFF;
        repeat (4) @(negedge clk);
        rd_val(12'hB00, v2);
        chk(v1 == v2, "R4", 64'(v2), 64'(v1));
        wr(12'hB03, 32'h77, 2'd3, "R4");
        repeat (3) @(negedge clk);
        rd_val(12'hB03, v1);
        chk(v1 == 32'h77, "R4", 64'(v1), 64'h77);
        wr(12'h320, 32'h0, 2'd3, "R4");

        // R5: write wins over a same-edge increment (counter 3 counts every edge)
        wr(12'hB03, 32'h100, 2'd3, "R5");
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = 12'hB03; wdata = 32'h2000; priv = 2'd3;
        @(negedge clk);
        we = 1'b0;
        #2 chk(rdata == 32'h2000, "R5", 64'(rdata), 64'h2000);
        @(negedge clk);
        en = 1'b0;

        // R6: half writes
        wr(12'hB83, 32'hABCD, 2'd3, "R6");
        rd_val(12'hB83, v1);
        chk(v1 == 32'hABCD, "R6", 64'(v1), 64'hABCD);
        wr(12'hB84, 32'h1234, 2'd3, "R6");
        wr(12'hB04, 32'h55, 2'd3, "R6");
        rd_val(12'hB84, v1);
        chk(v1 == 32'h1234, "R6", 64'(v1), 64'h1234);
        rd_val(12'hB04, v1);
        chk(v1 == 32'h55, "R6", 64'(v1), 64'h55);
        ev = '0;

        // R7: shadow equals machine copy (counter 4 idle)
        rd_val(12'hB04, v1);
        rd_val(12'hC04, v2);
        chk(v1 == v2, "R7", 64'(v2), 64'(v1));
        rd_val(12'hC84, v2);
        chk(v2 == 32'h1234, "R7", 64'(v2), 64'h1234);

        // R8: two-level read gating
        rd(12'hC00, 2'd1, "R8");
        rd(12'hC00, 2'd0, "R8");
        rd(12'hC00, 2'd3, "R8");
        wr(12'h306, 32'h1, 2'd3, "R8");
        rd(12'hC00, 2'd1, "R8");
        rd(12'hC00, 2'd0, "R8");
        wr(12'h106, 32'h1, 2'd1, "R8");
        rd(12'hC00, 2'd0, "R8");
        rd(12'hC02, 2'd0, "R8");
        rd(12'hB00, 2'd1, "R8");
        rd(12'h306, 2'd1, "R8");
        rd(12'h106, 2'd0, "R8");

        // R9: refused accesses
        wr(12'hC04, 32'hDEAD, 2'd3, "R9");
        rd_val(12'hB04, v1);
        chk(v1 == 32'h55, "R9", 64'(v1), 64'h55);
        wr(12'hB01, 32'h1, 2'd3, "R9");
        rd(12'hB09, 2'd3, "R9");
        rd(12'h7FF, 2'd3, "R9");
        wr(12'h323, 32'h3, 2'd1, "R9");
        rd_val(12'h323, v1);
        chk(v1 == 32'd5, "R9", 64'(v1), 64'd5);

        // R10: writable bits only
        wr(12'h320, 32'hFFFF_FFFF, 2'd3, "R10");
        rd_val(12'h320, v1);
        chk(v1 == 32'h1FD, "R10", 64'(v1), 64'h1FD);
        wr(12'h306, 32'hFFFF_FFFF, 2'd3, "R10");
        wr(12'h320, 32'h0, 2'd3, "R10");

        // constrained-random phase
        rand_ev = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [1:0]  p;
            int pr;
            a  = pick_addr();
            pr = int'($urandom % 3);
            p  = (pr == 0) ? 2'd0 : (pr == 1) ? 2'd1 : 2'd3;
            if ($urandom % 5 == 0) begin
                logic [31:0] d;
                d = (a[11:5] == 7'h19 && a[4:0] != 0) ? 32'($urandom % 32) :
                    (a == 12'h320) ? ($urandom & 32'h0F0) : $urandom;
                wr(a, d, p, tag_of(a, p));
            end else begin
                rd(a, p, tag_of(a, p));
            end
        end
        rand_ev = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule